// File: doc/BRIEF.md
# Signed 24-bit integer multiply execution unit

This block is the arithmetic stage of an integer multiply instruction. It takes two 32-bit register words and treats the low 24 bits of each as a two's-complement operand. It forms the full 48-bit signed product and hands back a 32-bit result for the register file. The result is the low 32 bits of the product. When the overflow-mode control bit is set and the product does not fit in 32 bits, the result is a saturated value instead. The block also works out the next condition-code word from the current flags, the written value and an overflow check.

The surrounding pipeline issues one operation per cycle on `op_en`, together with the destination register index and the current flags. One clock edge later the block presents the result, a write strobe, the echoed destination index and the next flag word. The flags change only for the low group of destination registers. The datapath is built from parameterised pieces: an operand-extract and multiply core, an overflow and saturation stage, and a flag-update stage. The multiply core comes in two variants, an inferred multiplier and an explicit shift-add array, and a parameter picks one of them.

Top module: `mpy24_exec_unit`

## Requirements
- R1: Only bits [23:0] of each source word form the operand, and bit 23 is its sign. Bits [31:24] have no effect on the result or on the flags.
- R2: When no overflow occurs, or when `sat_mode` is 0, `res_q` equals bits [31:0] of the 48-bit signed product.
- R3: Overflow means the 48-bit product lies outside the signed 32-bit range, so that any of product bits [47:32] differs from product bit 31. On a flag-updating operation, the V flag (`flags` bit 1) is 1 on overflow and 0 otherwise.
- R4: When `sat_mode` is 1 and overflow occurs, `res_q` is 32'h7FFF_FFFF if the true product is positive and 32'h8000_0000 if it is negative.
- R5: An operation issued with `op_en` high at a clock edge presents `res_q`, `wr_idx_q` (equal to `dst_idx`) and `wr_en_q`=1 right after that edge. After an edge with `op_en` low, `wr_en_q` is 0 and `res_q` and `wr_idx_q` hold their values.
- R6: The flags are updated only when `dst_idx` is 0 to 7. For indices 8 to 31, `flags_q` equals the `flags_in` presented with the operation.
- R7: On a flag-updating operation, LV (`flags` bit 5) becomes 1 on overflow and otherwise keeps its `flags_in` value.
- R8: On a flag-updating operation, N (bit 3) equals bit 31 of the written result and Z (bit 2) is 1 exactly when the written result is zero, both taken after any saturation. UF (bit 4) is 0. C (bit 0) and LUF (bit 6) copy `flags_in`.
- R9: While `rst_n` is low, `res_q`, `wr_en_q`, `wr_idx_q` and `flags_q` are all zero.
- R10: After an edge with `op_en` low, `flags_q` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Issue strobe for one multiply |
| src1_word | input | 32 | First source register word |
| src2_word | input | 32 | Second source register word |
| dst_idx | input | 5 | Destination register index |
| sat_mode | input | 1 | Overflow-mode control: 1 saturates on overflow |
| flags_in | input | 7 | Current flags {LUF,LV,UF,N,Z,V,C}, bit 6 down to bit 0 |
| res_q | output | 32 | Result to be written back |
| wr_en_q | output | 1 | Write strobe for the result |
| wr_idx_q | output | 5 | Destination index for the write |
| flags_q | output | 7 | Next flags, same layout as `flags_in` |

## Verification
Every result, the write strobe, the echoed index and the next flags are due one cycle after issue. They are registered at the clock edge that samples `op_en`, so the whole output set changes at a single edge. The driver applies each operation, or an idle cycle, on a falling edge and pushes the values it expects after the next rising edge. The monitor wakes one time unit after each rising edge and compares the oldest queued item against the ports, so each check looks at exactly the edge that consumed its stimulus. Idle items make the checks of hold behaviour (R5, R10) land on the right cycle as well.

// File: rtl/mpy24_pkg.sv
package mpy24_pkg;
   localparam int FLAG_W = 7;
   localparam int FL_C   = 0;
   localparam int FL_V   = 1;
   localparam int FL_Z   = 2;
   localparam int FL_N   = 3;
   localparam int FL_UF  = 4;
   localparam int FL_LV  = 5;
   localparam int FL_LUF = 6;

   typedef enum logic [0:0] {
      MULT_INFER = 1'b0,
      MULT_ARRAY = 1'b1
   } mult_style_e;
endpackage

// File: rtl/mpy24_mult.sv
module mpy24_mult
   import mpy24_pkg::*;
#(
   parameter int          WORD_W = 32,
   parameter int          OP_W   = 24,
   parameter mult_style_e STYLE  = MULT_INFER,
   localparam int         PROD_W = 2 * OP_W
) (
   input  logic [WORD_W-1:0] a_word,
   input  logic [WORD_W-1:0] b_word,
   output logic [PROD_W-1:0] prod
);
   if (OP_W < 2 || OP_W > WORD_W) begin : g_bad_opw
      $error("mpy24_mult: OP_W must lie in 2..WORD_W");
   end

   logic [OP_W-1:0]   a_op;
   logic [OP_W-1:0]   b_op;
   logic [PROD_W-1:0] a_ext;
   logic [PROD_W-1:0] b_ext;

   assign a_op  = a_word[OP_W-1:0];
   assign b_op  = b_word[OP_W-1:0];
   assign a_ext = {{OP_W{a_op[OP_W-1]}}, a_op};
   assign b_ext = {{OP_W{b_op[OP_W-1]}}, b_op};

   if (STYLE == MULT_INFER) begin : g_infer
      assign prod = PROD_W'($signed(a_ext) * $signed(b_ext));
   end else begin : g_array
      logic [OP_W:0][PROD_W-1:0] acc;
      assign acc[0] = '0;
      for (genvar i = 0; i < OP_W; i++) begin : g_row
         logic [PROD_W-1:0] pp;
         assign pp = b_op[i] ? (a_ext << i) : '0;
         if (i == OP_W - 1) begin : g_sign_row
            assign acc[i+1] = acc[i] - pp;
         end else begin : g_mag_row
            assign acc[i+1] = acc[i] + pp;
         end
      end
      assign prod = acc[OP_W];
   end
endmodule

// File: rtl/mpy24_ovf_sat.sv
module mpy24_ovf_sat #(
   parameter int PROD_W = 48,
   parameter int RES_W  = 32,
   localparam int UP_W  = PROD_W - RES_W + 1
) (
   input  logic [PROD_W-1:0] prod,
   input  logic              sat_en,
   output logic [RES_W-1:0]  res,
   output logic              ovf
);
   if (RES_W >= PROD_W || RES_W < 2) begin : g_bad_resw
      $error("mpy24_ovf_sat: RES_W must be below PROD_W");
   end

   logic [UP_W-1:0]  upper;
   logic [RES_W-1:0] sat_pos;
   logic [RES_W-1:0] sat_neg;

   assign upper   = prod[PROD_W-1:RES_W-1];
   assign ovf     = !((&upper) || !(|upper));
   assign sat_pos = {1'b0, {(RES_W-1){1'b1}}};
   assign sat_neg = {1'b1, {(RES_W-1){1'b0}}};

   always_comb begin
      if (sat_en && ovf) begin
         res = prod[PROD_W-1] ? sat_neg : sat_pos;
      end else begin
         res = prod[RES_W-1:0];
      end
   end
endmodule

// File: rtl/mpy24_flags.sv
module mpy24_flags
   import mpy24_pkg::*;
#(
   parameter int RES_W     = 32,
   parameter int IDX_W     = 5,
   parameter int FLAG_REGS = 8
) (
   input  logic [RES_W-1:0]  res,
   input  logic              ovf,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_next
);
   if (FLAG_REGS < 1 || FLAG_REGS > (1 << IDX_W)) begin : g_bad_regs
      $error("mpy24_flags: FLAG_REGS out of index range");
   end

   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(FLAG_REGS);

   logic upd;
   assign upd = {1'b0, dst_idx} < LIMIT;

   always_comb begin
      flags_next = flags_in;
      if (upd) begin
         flags_next[FL_V]  = ovf;
         flags_next[FL_LV] = flags_in[FL_LV] | ovf;
         flags_next[FL_UF] = 1'b0;
         flags_next[FL_N]  = res[RES_W-1];
         flags_next[FL_Z]  = (res == '0);
      end
   end
endmodule

// File: rtl/mpy24_exec_unit.sv
module mpy24_exec_unit
   import mpy24_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          OP_W      = 24,
   parameter int          RES_W     = 32,
   parameter int          IDX_W     = 5,
   parameter int          FLAG_REGS = 8,
   parameter mult_style_e STYLE     = MULT_ARRAY,
   localparam int         PROD_W    = 2 * OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en,
   input  logic [WORD_W-1:0] src1_word,
   input  logic [WORD_W-1:0] src2_word,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic              sat_mode,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [RES_W-1:0]  res_q,
   output logic              wr_en_q,
   output logic [IDX_W-1:0]  wr_idx_q,
   output logic [FLAG_W-1:0] flags_q
);
   if (RES_W > WORD_W) begin : g_bad_res
      $error("mpy24_exec_unit: RES_W must not exceed WORD_W");
   end

   logic [PROD_W-1:0] prod;
   logic [RES_W-1:0]  res_d;
   logic              ovf;
   logic [FLAG_W-1:0] flags_d;

   mpy24_mult #(
      .WORD_W (WORD_W),
      .OP_W   (OP_W),
      .STYLE  (STYLE)
   ) u_mult (
      .a_word (src1_word),
      .b_word (src2_word),
      .prod   (prod)
   );

   mpy24_ovf_sat #(
      .PROD_W (PROD_W),
      .RES_W  (RES_W)
   ) u_ovf (
      .prod   (prod),
      .sat_en (sat_mode),
      .res    (res_d),
      .ovf    (ovf)
   );

   mpy24_flags #(
      .RES_W     (RES_W),
      .IDX_W     (IDX_W),
      .FLAG_REGS (FLAG_REGS)
   ) u_flags (
      .res        (res_d),
      .ovf        (ovf),
      .dst_idx    (dst_idx),
      .flags_in   (flags_in),
      .flags_next (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= '0;
         wr_en_q  <= 1'b0;
         wr_idx_q <= '0;
         flags_q  <= '0;
      end else begin
         wr_en_q <= op_en;
         if (op_en) begin
            res_q    <= res_d;
            wr_idx_q <= dst_idx;
            flags_q  <= flags_d;
         end else begin
            flags_q  <= flags_in;
         end
      end
   end

   localparam logic [IDX_W:0] FLIM = (IDX_W+1)'(FLAG_REGS);

   logic in_low;
   assign in_low = {1'b0, dst_idx} < FLIM;

   assert_wr_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |=> (wr_en_q && wr_idx_q == $past(dst_idx)));

   assert_hold_res_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> (!wr_en_q && $stable(res_q)));

   assert_flag_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && !in_low) |=> (flags_q == $past(flags_in)));

   assert_lv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && in_low && flags_in[FL_LV]) |=> flags_q[FL_LV]);

   assert_nz_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && in_low) |=> (flags_q[FL_Z] == (res_q == '0)
                            && flags_q[FL_N] == res_q[RES_W-1]
                            && !flags_q[FL_UF]));

   assert_sat_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && in_low && sat_mode) |=> (!flags_q[FL_V]
         || res_q == {1'b0, {(RES_W-1){1'b1}}}
         || res_q == {1'b1, {(RES_W-1){1'b0}}}));

   assert_idle_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> (flags_q == $past(flags_in)));
endmodule

// File: tb/mpy24_exec_unit_bench.sv
module mpy24_exec_unit_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] res;
      logic        wr;
      logic [4:0]  idx;
      logic [6:0]  fl;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_en = 1'b0;
   logic [31:0] src1_word = '0;
   logic [31:0] src2_word = '0;
   logic [4:0]  dst_idx = '0;
   logic        sat_mode = 1'b0;
   logic [6:0]  flags_in = '0;
   logic [31:0] res_q;
   logic        wr_en_q;
   logic [4:0]  wr_idx_q;
   logic [6:0]  flags_q;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t exp_q[$];
   logic [31:0] last_res = '0;
   logic [4:0]  last_idx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpy24_exec_unit u_mpy24_exec_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_en     (op_en),
      .src1_word (src1_word),
      .src2_word (src2_word),
      .dst_idx   (dst_idx),
      .sat_mode  (sat_mode),
      .flags_in  (flags_in),
      .res_q     (res_q),
      .wr_en_q   (wr_en_q),
      .wr_idx_q  (wr_idx_q),
      .flags_q   (flags_q)
   );

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic issue(input bit en, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] d, input bit sat, input logic [6:0] fin,
                        input string tag);
      exp_t   e;
      longint pa, pb, p;
      bit     ov;
      logic [31:0] r;
      @(negedge clk);
      op_en = en; src1_word = a; src2_word = b; dst_idx = d;
      sat_mode = sat; flags_in = fin;
      pa = longint'($signed(a[23:0]));
      pb = longint'($signed(b[23:0]));
      p  = pa * pb;
      ov = (p > 64'sd2147483647) || (p < -64'sd2147483648);
      if (sat && ov) r = (p < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else           r = p[31:0];
      e.fl = fin;
      if (en) begin
         last_res = r;
         last_idx = d;
         if (d < 8) begin
            e.fl[1] = ov;
            e.fl[5] = fin[5] | ov;
            e.fl[4] = 1'b0;
            e.fl[3] = r[31];
            e.fl[2] = (r == 0);
         end
      end
      e.res = last_res;
      e.idx = last_idx;
      e.wr  = en;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (res_q !== e.res || wr_en_q !== e.wr || wr_idx_q !== e.idx || flags_q !== e.fl) begin
            n_fail++;
            $display("FAIL %s: res=%h wr=%b idx=%0d fl=%b expected res=%h wr=%b idx=%0d fl=%b",
                     e.tag, res_q, wr_en_q, wr_idx_q, flags_q, e.res, e.wr, e.idx, e.fl);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if (res_q !== 0 || wr_en_q !== 0 || wr_idx_q !== 0 || flags_q !== 0) begin
         n_fail++;
         $display("FAIL R9: res=%h wr=%b idx=%0d fl=%b expected all zero",
                  res_q, wr_en_q, wr_idx_q, flags_q);
      end
      rst_n = 1'b1;
      // R2 plain products, positive and negative
      issue(1, 32'h0000_0003, 32'h0000_0005, 5'd1, 0, 7'b0000000, "R2");
      issue(1, 32'h00FF_FFFF, 32'h00FF_FFFF, 5'd2, 0, 7'b0000000, "R2");
      issue(1, 32'h00FF_FFFE, 32'h0000_0007, 5'd3, 0, 7'b1000001, "R8");
      // R1 upper garbage bits ignored
      issue(1, 32'hFF00_0003, 32'hA500_0002, 5'd4, 0, 7'b0000000, "R1");
      issue(1, 32'h7F80_0000, 32'h0100_0001, 5'd0, 0, 7'b0000000, "R1");
      // R8 zero result
      issue(1, 32'h0000_0000, 32'h0012_3456, 5'd5, 0, 7'b0011010, "R8");
      // R3 overflow with truncation
      issue(1, 32'h007F_FFFF, 32'h007F_FFFF, 5'd6, 0, 7'b0000000, "R3");
      issue(1, 32'h0001_0000, 32'h0000_8000, 5'd7, 0, 7'b0000000, "R3");
      issue(1, 32'h0080_0000, 32'h0080_0000, 5'd0, 0, 7'b0000000, "R3");
      // R4 saturation both signs
      issue(1, 32'h007F_FFFF, 32'h007F_FFFF, 5'd1, 1, 7'b0000000, "R4");
      issue(1, 32'h0080_0000, 32'h007F_FFFF, 5'd2, 1, 7'b0000000, "R4");
      issue(1, 32'h0001_0000, 32'h0000_8000, 5'd3, 1, 7'b0000000, "R4");
      issue(1, 32'h0000_0003, 32'h0000_0005, 5'd3, 1, 7'b0000000, "R4");
      // R7 sticky LV kept without overflow
      issue(1, 32'h0000_0002, 32'h0000_0002, 5'd4, 0, 7'b0100000, "R7");
      issue(1, 32'h0000_0002, 32'h0000_0002, 5'd4, 0, 7'b0000010, "R7");
      // R6 boundary at 7 and 8, high index
      issue(1, 32'h007F_FFFF, 32'h007F_FFFF, 5'd8, 0, 7'b0011001, "R6");
      issue(1, 32'h0000_0000, 32'h0000_0000, 5'd27, 1, 7'b1010100, "R6");
      issue(1, 32'h0000_0000, 32'h0000_0001, 5'd31, 0, 7'b0101010, "R6");
      // R5/R10 idle cycles hold result, pass flags
      issue(0, 32'h0000_0009, 32'h0000_0009, 5'd2, 0, 7'b1111111, "R10");
      issue(0, 32'h0000_0001, 32'h0000_0001, 5'd0, 1, 7'b0000101, "R5");
      issue(1, 32'h00FF_FFFF, 32'h0000_0001, 5'd7, 0, 7'b0000000, "R5");
      issue(0, 32'h0000_0000, 32'h0000_0000, 5'd0, 0, 7'b0000000, "R5");
      issue(0, 32'h0000_0000, 32'h0000_0000, 5'd0, 0, 7'b0000000, "R10");
      repeat (3) @(negedge clk);
      report();
   end
endmodule